// File: doc/BRIEF.md
# Escaped Frame Message Receiver

This block sits on the inbound side of a management link that carries byte-stuffed frames from a virtual machine. It accepts one byte per cycle over a valid/ready handshake and removes the escape stuffing. Payload bytes go into a small local buffer. Two terminator symbols tell a message frame from a command frame. A message is then checked for minimum length and a zero modular sum. If it passes, it is rearranged into the layout the register side expects: the checksum byte is dropped from the count, and the first two bytes trade places.

The register interface sees the result as a level, `msg_ready`, together with the stored length and a random-access read port into the buffer. An attention strobe fires whenever a message frame closes cleanly. An error strobe with a two-bit kind reports frames that are dropped. A command strobe with a two-bit kind reports which command a command frame carries. While a message waits for the register side, or while that side signals busy, the input is held off. A one-cycle clear pulse from the register side restarts reception.

Top module: `frame_rx`

## Requirements
- R1: After reset, `in_ready` is high (with `bmc_busy` low), `msg_len` is 0, and `msg_ready`, `attn_stb`, `err_stb` and `cmd_stb` are low.
- R2: The byte 0xAA is an escape. The next byte that is neither 0xA0, 0xA1 nor 0xAA is stored with bit 4 forced to 0, and the escape is then spent. All other non-symbol bytes are stored unchanged.
- R3: A terminator (0xA0 or 0xA1) arriving while an escape is pending drops the frame. In the cycle after the terminator is accepted, `err_stb` pulses for one cycle with `err_kind` 0 and `msg_len` reads 0.
- R4: Once DEPTH bytes are stored, a further data byte sets a sticky overflow. While overflow is set, bytes are not stored and 0xAA is ignored. The next terminator drops the frame with `err_stb` and `err_kind` 1 in the following cycle.
- R5: A terminator accepted while no byte is stored has no effect: no strobe, and no change in `msg_len` or `in_ready`.
- R6: A clean 0xA0 (bytes stored, no escape, no overflow) pulses `attn_stb` in the following cycle, and `in_ready` is low in that cycle.
- R7: One cycle after `attn_stb`, a message with fewer than MIN_LEN stored bytes is dropped with `err_kind` 2. Otherwise, a message whose stored bytes do not sum to 0 modulo 256 is dropped with `err_kind` 3. In both cases `msg_len` becomes 0.
- R8: One cycle after `attn_stb`, a valid message raises `msg_ready`, which stays high until cleared. `msg_len` becomes the stored count minus one. Buffer entries 0 and 1 are exchanged, and the remaining entries are unchanged.
- R9: A clean 0xA1 pulses `cmd_stb` in the following cycle and clears the stored bytes. `cmd_kind` is 1 if the first byte is 0xFF, 2 if it is 0x08 with at least two bytes stored, 3 if it is 0x04, and 0 otherwise.
- R10: `in_ready` is low while `msg_ready` or `bmc_busy` is high, and bytes offered then are not taken.
- R11: A `state_clr` pulse clears `msg_ready`, the stored length, a pending escape and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inbound byte offered |
| in_data | input | 8 | Inbound stuffed byte |
| in_ready | output | 1 | Receiver can take a byte |
| bmc_busy | input | 1 | Register side busy; holds the input off |
| state_clr | input | 1 | One-cycle pulse restarting reception |
| rd_addr | input | clog2(DEPTH) | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| msg_len | output | clog2(DEPTH+1) | Stored byte count |
| msg_ready | output | 1 | A validated message waits |
| attn_stb | output | 1 | Message frame closed cleanly |
| err_stb | output | 1 | Frame dropped |
| err_kind | output | 2 | Drop reason, valid with `err_stb` |
| cmd_stb | output | 1 | Command frame closed |
| cmd_kind | output | 2 | Command class, valid with `cmd_stb` |

## Verification
The bench builds the receiver with DEPTH set to 16 and MIN_LEN left at 4. The shallow buffer puts the overflow boundary, the sticky flag and the escape that is ignored after it within a frame of about twenty bytes. Random frames of up to twelve bytes still hit both the short-message and bad-sum paths, as well as stuffing of every special symbol, including a stuffed checksum byte.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  localparam logic [7:0] SYM_MSG_END = 8'hA0;
  localparam logic [7:0] SYM_CMD_END = 8'hA1;
  localparam logic [7:0] SYM_ESC     = 8'hAA;
  localparam logic [7:0] ESC_MASK    = 8'h10;

  localparam logic [7:0] OP_VERSION  = 8'hFF;
  localparam logic [7:0] OP_CAPS     = 8'h08;
  localparam logic [7:0] OP_RESET    = 8'h04;

  typedef enum logic [1:0] {
    ERR_ESC_END  = 2'd0,
    ERR_TOO_LONG = 2'd1,
    ERR_SHORT    = 2'd2,
    ERR_BAD_SUM  = 2'd3
  } err_kind_e;

  typedef enum logic [1:0] {
    CMD_OTHER   = 2'd0,
    CMD_VERSION = 2'd1,
    CMD_CAPS    = 2'd2,
    CMD_RESET   = 2'd3
  } cmd_kind_e;

  function automatic logic is_symbol(input logic [7:0] b);
    return (b == SYM_MSG_END) || (b == SYM_CMD_END) || (b == SYM_ESC);
  endfunction

  function automatic logic [7:0] unstuff(input logic [7:0] b, input logic esc);
    return esc ? (b & ~ESC_MASK) : b;
  endfunction

  function automatic logic [7:0] sum_step(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  function automatic cmd_kind_e classify_cmd(input logic [7:0] op, input logic has_arg);
    if (op == OP_VERSION) return CMD_VERSION;
    if (op == OP_CAPS && has_arg) return CMD_CAPS;
    if (op == OP_RESET) return CMD_RESET;
    return CMD_OTHER;
  endfunction

endpackage

// File: rtl/frame_rx_escape.sv
module frame_rx_escape
  import frame_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  input  logic       ovf_i,
  input  logic       clr_i,
  output logic       esc_o,
  output logic       data_ev_o,
  output logic [7:0] data_o,
  output logic       msg_end_o,
  output logic       cmd_end_o
);

  logic esc_q;
  logic esc_in;

  always_comb begin
    esc_in    = take_i && (byte_i == SYM_ESC);
    msg_end_o = take_i && (byte_i == SYM_MSG_END);
    cmd_end_o = take_i && (byte_i == SYM_CMD_END);
    data_ev_o = take_i && !is_symbol(byte_i);
    data_o    = unstuff(byte_i, esc_q);
    esc_o     = esc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                esc_q <= 1'b0;
    else if (clr_i)            esc_q <= 1'b0;
    else if (esc_in && !ovf_i) esc_q <= 1'b1;
    else if (data_ev_o)        esc_q <= 1'b0;
  end

  // R4
  escape_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_q |-> !ovf_i);

  // R2
  escape_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_q && data_ev_o) |=> !esc_q);

endmodule

// File: rtl/frame_rx_buffer.sv
module frame_rx_buffer
  import frame_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ev_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          clr_i,
  input  logic          swap_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    head_o,
  output logic [LW-1:0] len_o,
  output logic [7:0]    sum_o,
  output logic          ovf_o
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] len_q;
  logic [7:0]    sum_q;
  logic          ovf_q;
  logic          full;
  logic          wr_ok;
  logic          ovf_hit;

  always_comb begin
    full    = (len_q == FULL);
    wr_ok   = wr_ev_i && !ovf_q && !full && !clr_i;
    ovf_hit = wr_ev_i && !ovf_q && full && !clr_i;
  end

  always_ff @(posedge clk) begin
    if (swap_i) begin
      mem[0] <= mem[1];
      mem[1] <= mem[0];
    end else if (wr_ok) begin
      mem[len_q[AW-1:0]] <= wr_byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      len_q <= '0;
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (swap_i)     len_q <= len_q - 1'b1;
      else if (wr_ok) len_q <= len_q + 1'b1;
      if (wr_ok)      sum_q <= sum_step(sum_q, wr_byte_i);
      if (ovf_hit)    ovf_q <= 1'b1;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign head_o    = mem[0];
  assign len_o     = len_q;
  assign sum_o     = sum_q;
  assign ovf_o     = ovf_q;

  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= FULL);

  // R4
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (len_q == FULL));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int MIN_LEN = 4,
  parameter int LW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_end_i,
  input  logic          cmd_end_i,
  input  logic          esc_i,
  input  logic          ovf_i,
  input  logic [LW-1:0] len_i,
  input  logic [7:0]    sum_i,
  input  logic [7:0]    head_i,
  input  logic          state_clr_i,
  input  logic          bmc_busy_i,
  output logic          in_ready_o,
  output logic          frame_clr_o,
  output logic          swap_o,
  output logic          waiting_o,
  output logic          attn_o,
  output logic          err_o,
  output logic [1:0]    err_kind_o,
  output logic          cmd_o,
  output logic [1:0]    cmd_kind_o
);

  logic      waiting_q, val_pend_q;
  logic      attn_q, err_q, cmd_q;
  err_kind_e err_kind_q;
  cmd_kind_e cmd_kind_q;

  logic term, empty, broken, go_check, go_cmd;
  logic chk_short, chk_bad, chk_fail;
  err_kind_e err_next;

  always_comb begin
    term      = msg_end_i || cmd_end_i;
    empty     = (len_i == '0);
    broken    = term && (esc_i || ovf_i);
    go_check  = msg_end_i && !esc_i && !ovf_i && !empty;
    go_cmd    = cmd_end_i && !esc_i && !ovf_i && !empty;
    chk_short = len_i < LW'(MIN_LEN);
    chk_bad   = (sum_i != 8'h00);
    chk_fail  = val_pend_q && (chk_short || chk_bad);
    swap_o    = val_pend_q && !chk_fail && !state_clr_i;
    frame_clr_o = state_clr_i || broken || go_cmd || chk_fail;
    in_ready_o  = !waiting_q && !val_pend_q && !bmc_busy_i;
    if (esc_i)          err_next = ERR_ESC_END;
    else if (ovf_i)     err_next = ERR_TOO_LONG;
    else if (chk_short) err_next = ERR_SHORT;
    else                err_next = ERR_BAD_SUM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q  <= 1'b0;
      val_pend_q <= 1'b0;
      attn_q     <= 1'b0;
      err_q      <= 1'b0;
      cmd_q      <= 1'b0;
      err_kind_q <= ERR_ESC_END;
      cmd_kind_q <= CMD_OTHER;
    end else begin
      attn_q <= go_check;
      err_q  <= broken || chk_fail;
      cmd_q  <= go_cmd;
      if (broken || chk_fail) err_kind_q <= err_next;
      if (go_cmd) cmd_kind_q <= classify_cmd(head_i, len_i >= LW'(2));
      if (state_clr_i) begin
        waiting_q  <= 1'b0;
        val_pend_q <= 1'b0;
      end else begin
        val_pend_q <= go_check;
        if (swap_o) waiting_q <= 1'b1;
      end
    end
  end

  assign waiting_o  = waiting_q;
  assign attn_o     = attn_q;
  assign err_o      = err_q;
  assign err_kind_o = err_kind_q;
  assign cmd_o      = cmd_q;
  assign cmd_kind_o = cmd_kind_q;

  // R6
  attn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn_q |-> !in_ready_o);

  // R8
  wait_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting_q) |-> $past(val_pend_q));

  // R8
  wait_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && !state_clr_i) |=> waiting_q);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({attn_q, err_q, cmd_q}) <= 1);

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MIN_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [7:0]                   in_data,
  output logic                         in_ready,
  input  logic                         bmc_busy,
  input  logic                         state_clr,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [7:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   msg_len,
  output logic                         msg_ready,
  output logic                         attn_stb,
  output logic                         err_stb,
  output logic [1:0]                   err_kind,
  output logic                         cmd_stb,
  output logic [1:0]                   cmd_kind
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic          take;
  logic          esc, data_ev, msg_end, cmd_end;
  logic [7:0]    data_byte, head, sum;
  logic          ovf, frame_clr, swap;
  logic [LW-1:0] len;

  assign take = in_valid && in_ready;

  frame_rx_escape u_esc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .byte_i    (in_data),
    .ovf_i     (ovf),
    .clr_i     (frame_clr),
    .esc_o     (esc),
    .data_ev_o (data_ev),
    .data_o    (data_byte),
    .msg_end_o (msg_end),
    .cmd_end_o (cmd_end)
  );

  frame_rx_buffer #(.DEPTH(DEPTH), .LW(LW), .AW(AW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ev_i   (data_ev),
    .wr_byte_i (data_byte),
    .clr_i     (frame_clr),
    .swap_i    (swap),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .head_o    (head),
    .len_o     (len),
    .sum_o     (sum),
    .ovf_o     (ovf)
  );

  frame_rx_ctrl #(.MIN_LEN(MIN_LEN), .LW(LW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_end_i   (msg_end),
    .cmd_end_i   (cmd_end),
    .esc_i       (esc),
    .ovf_i       (ovf),
    .len_i       (len),
    .sum_i       (sum),
    .head_i      (head),
    .state_clr_i (state_clr),
    .bmc_busy_i  (bmc_busy),
    .in_ready_o  (in_ready),
    .frame_clr_o (frame_clr),
    .swap_o      (swap),
    .waiting_o   (msg_ready),
    .attn_o      (attn_stb),
    .err_o       (err_stb),
    .err_kind_o  (err_kind),
    .cmd_o       (cmd_stb),
    .cmd_kind_o  (cmd_kind)
  );

  assign msg_len = len;

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmc_busy && !state_clr) |=> $stable(len) || err_stb || cmd_stb || msg_ready);

endmodule

// File: tb/tb_frame_rx.sv
`timescale 1ns/1ps
module tb_frame_rx;
  localparam int DEPTH   = 16;
  localparam int MIN_LEN = 4;
  localparam int AW      = $clog2(DEPTH);
  localparam int LW      = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic          bmc_busy = 1'b0;
  logic          state_clr = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [LW-1:0] msg_len;
  logic          msg_ready, attn_stb, err_stb, cmd_stb;
  logic [1:0]    err_kind, cmd_kind;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] frm [32];
  int         frm_n;

  always #2.5 clk = ~clk;

  frame_rx #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bmc_busy(bmc_busy), .state_clr(state_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .msg_len(msg_len),
    .msg_ready(msg_ready), .attn_stb(attn_stb), .err_stb(err_stb),
    .err_kind(err_kind), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] neg_sum(input int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + frm[i];
    return 8'h00 - s;
  endfunction

  function automatic logic [7:0] expect_byte(input int i);
    if (i == 0) return frm[1];
    if (i == 1) return frm[0];
    return frm[i];
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_stuffed(input logic [7:0] b);
    if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
      push(8'hAA);
      push(b | 8'h10);
    end else begin
      push(b);
    end
  endtask

  task automatic send_body();
    for (int i = 0; i < frm_n; i++) push_stuffed(frm[i]);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    state_clr = 1'b1;
    @(negedge clk);
    state_clr = 1'b0;
  endtask

  // after the 0xA0 has been pushed: checks attention, then the outcome
  task automatic check_msg_outcome(input int code, input string req);
    check({"R6 attn ", req}, attn_stb, 1);
    check({"R6 ready low ", req}, in_ready, 0);
    @(negedge clk);
    if (code < 0) begin
      check({"R8 msg_ready ", req}, msg_ready, 1);
      check({"R8 len ", req}, msg_len, frm_n - 1);
      check({"R8 no err ", req}, err_stb, 0);
      for (int i = 0; i < frm_n - 1; i++) begin
        rd_addr = AW'(i);
        #1;
        check({"R8 byte ", req}, rd_data, expect_byte(i));
      end
      check({"R10 ready low while waiting ", req}, in_ready, 0);
    end else begin
      check({"R7 err ", req}, err_stb, 1);
      check({"R7 kind ", req}, err_kind, code);
      check({"R7 len cleared ", req}, msg_len, 0);
      check({"R7 no msg_ready ", req}, msg_ready, 0);
    end
  endtask

  task automatic send_cmd(input int n, input int kind);
    frm_n = n;
    send_body();
    push(8'hA1);
    check("R9 cmd_stb", cmd_stb, 1);
    check("R9 cmd_kind", cmd_kind, kind);
    check("R9 len cleared", msg_len, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready, 1);
    check("R1 msg_len", msg_len, 0);
    check("R1 msg_ready", msg_ready, 0);
    check("R1 strobes", {attn_stb, err_stb, cmd_stb}, 0);

    // R10 busy holds off input
    bmc_busy = 1'b1;
    #1;
    check("R10 ready low on busy", in_ready, 0);
    in_valid = 1'b1; in_data = 8'h55;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    check("R10 nothing taken", msg_len, 0);
    bmc_busy = 1'b0;
    #1;
    check("R10 ready back", in_ready, 1);

    // R5 empty terminator
    push(8'hA0);
    check("R5 no strobes", {attn_stb, err_stb, cmd_stb}, 0);
    check("R5 ready", in_ready, 1);
    check("R5 len", msg_len, 0);
    push(8'hA1);
    check("R5 no cmd strobe", {attn_stb, err_stb, cmd_stb}, 0);

    // R2 escape decode: 0xAA then 0x3F stored as 0x2F
    push(8'h11); push(8'hAA); push(8'h3F); push(8'h22);
    check("R2 len", msg_len, 3);
    frm[0] = 8'h11; frm[1] = 8'h2F; frm[2] = 8'h22;
    frm[3] = neg_sum(3); frm_n = 4;
    push_stuffed(frm[3]);
    push(8'hA0);
    check_msg_outcome(-1, "R2 escaped");
    pulse_clr();
    // R11 clear
    check("R11 msg_ready cleared", msg_ready, 0);
    check("R11 len cleared", msg_len, 0);
    check("R11 ready back", in_ready, 1);

    // R3 terminator after escape
    push(8'h05); push(8'hAA); push(8'hA0);
    check("R3 err", err_stb, 1);
    check("R3 kind", err_kind, 0);
    check("R3 len", msg_len, 0);
    check("R3 no attn", attn_stb, 0);
    @(negedge clk);
    check("R3 pulse ends", err_stb, 0);

    // R4 overflow, escape ignored after it
    for (int i = 0; i < DEPTH; i++) push(8'(i + 1));
    check("R4 full len", msg_len, DEPTH);
    push(8'h77); push(8'h78);
    check("R4 len held", msg_len, DEPTH);
    push(8'hAA);
    push(8'hA0);
    check("R4 err", err_stb, 1);
    check("R4 kind too long", err_kind, 1);
    check("R4 len cleared", msg_len, 0);

    // R11 pending escape cleared by state_clr
    push(8'hAA);
    pulse_clr();
    frm[0] = 8'h10; frm[1] = 8'h20; frm[2] = 8'h30;
    frm[3] = neg_sum(3); frm_n = 4;
    send_body();
    push(8'hA0);
    check_msg_outcome(-1, "R11 escape cleared");
    pulse_clr();

    // R7 short and bad sum
    frm[0] = 8'h01; frm[1] = 8'h02; frm[2] = neg_sum(2); frm_n = 3;
    send_body(); push(8'hA0);
    check_msg_outcome(2, "R7 short");
    frm[0] = 8'h01; frm[1] = 8'h02; frm[2] = 8'h03; frm[3] = 8'h04; frm_n = 4;
    send_body(); push(8'hA0);
    check_msg_outcome(3, "R7 bad sum");

    // R9 commands
    frm[0] = 8'hFF; send_cmd(1, 1);
    frm[0] = 8'h08; send_cmd(1, 0);
    frm[0] = 8'h08; frm[1] = 8'h01; send_cmd(2, 2);
    frm[0] = 8'h04; send_cmd(1, 3);
    frm[0] = 8'h33; send_cmd(1, 0);

    // random messages
    for (int k = 0; k < 60; k++) begin
      int  n;
      bit  corrupt;
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n - 1; i++) begin
        case ($urandom % 8)
          0: frm[i] = 8'hA0;
          1: frm[i] = 8'hA1;
          2: frm[i] = 8'hAA;
          default: frm[i] = 8'($urandom);
        endcase
      end
      frm[n-1] = neg_sum(n - 1);
      corrupt = ($urandom % 4) == 0;
      if (corrupt) frm[n-1] = frm[n-1] + 8'(1 + ($urandom % 255));
      frm_n = n;
      send_body();
      push(8'hA0);
      if (n < MIN_LEN) check_msg_outcome(2, "R7 rand short");
      else if (corrupt) check_msg_outcome(3, "R7 rand sum");
      else begin
        check_msg_outcome(-1, "R8 rand");
        pulse_clr();
      end
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule